// File: doc/BRIEF.md
# Six-Mode Funnel Shifter

This block is a purely combinational N-bit shifter. It does rotates, logical shifts and arithmetic shifts in both directions, all through one shared datapath. The default width is 8 bits. The operand and the mode first set the fill of an intermediate word that is 2N-1 bits wide. The block then takes an N-bit window of that word. A chain of log2 N two-input multiplexer stages picks the window, and each bit of the window offset drives one of those stages directly.

Right-type operations use the shift amount as the window offset. Left-type operations use its bitwise complement, which equals N-1-k. So no operation needs an adder or a decoder in front of the multiplexer chain. Mode codes that are not assigned to an operation pass the operand through unchanged.

Top module: `funnel_shifter`

## Requirements
- R1: Mode code 0 (rotate right) gives y[j] = a[(j+k) mod N] for every bit j.
- R2: Mode code 1 (logical right) gives y[j] = a[j+k] when j+k < N, and 0 otherwise.
- R3: Mode code 2 (arithmetic right) gives y[j] = a[j+k] when j+k < N, and a[N-1] otherwise.
- R4: Mode code 3 (rotate left) gives y[j] = a[(j-k+N) mod N] for every bit j.
- R5: Mode codes 4 (logical left) and 5 (arithmetic left) both give y[j] = a[j-k] when j >= k, and 0 otherwise.
- R6: With k = 0, every mode code from 0 to 5 returns y equal to a.
- R7: Mode codes 6 and 7 return y equal to a, and the shift amount has no effect.
- R8: The output depends only on the present inputs and settles in the same cycle the inputs change. There is no storage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | Operand |
| amt_i | input | $clog2(WIDTH) | Shift amount k, from 0 to WIDTH-1 |
| mode_i | input | 3 | Operation code (0 to 5 assigned, 6 and 7 pass through) |
| y_o | output | WIDTH | Shifted or rotated result |

## Verification
The assertions assume WIDTH is a power of two, so that every amount code is a legal shift. They also assume the inputs carry no unknown bits, and they skip evaluation while any input is unknown. The stimulus drives only fully known values. It sweeps every operand, every amount and all eight mode codes at the default width, including the unassigned codes. Each result is compared with a bitwise model written from the index formulas above.

// File: rtl/funnel_shifter_pkg.sv
package funnel_shifter_pkg;

  typedef enum logic [2:0] {
    SH_ROT_R = 3'd0,
    SH_LOG_R = 3'd1,
    SH_ARI_R = 3'd2,
    SH_ROT_L = 3'd3,
    SH_LOG_L = 3'd4,
    SH_ARI_L = 3'd5,
    SH_PASS6 = 3'd6,
    SH_PASS7 = 3'd7
  } shift_mode_e;

endpackage

// File: rtl/fsh_fill.sv
// Builds the 2N-1 bit source word and the window offset from the mode.
module fsh_fill
  import funnel_shifter_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int AMT_W = $clog2(WIDTH),
  localparam int ZW = 2 * WIDTH - 1
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic [2:0]       mode_i,
  output logic [ZW-1:0]    z_o,
  output logic [AMT_W-1:0] off_o
);

  shift_mode_e mode;
  assign mode = shift_mode_e'(mode_i);

  always_comb begin
    unique case (mode)
      SH_ROT_R: begin
        z_o   = {a_i[WIDTH-2:0], a_i};
        off_o = amt_i;
      end
      SH_LOG_R: begin
        z_o   = {{(WIDTH-1){1'b0}}, a_i};
        off_o = amt_i;
      end
      SH_ARI_R: begin
        z_o   = {{(WIDTH-1){a_i[WIDTH-1]}}, a_i};
        off_o = amt_i;
      end
      SH_ROT_L: begin
        z_o   = {a_i, a_i[WIDTH-1:1]};
        off_o = ~amt_i;
      end
      SH_LOG_L, SH_ARI_L: begin
        z_o   = {a_i, {(WIDTH-1){1'b0}}};
        off_o = ~amt_i;
      end
      default: begin
        z_o   = {{(WIDTH-1){1'b0}}, a_i};
        off_o = '0;
      end
    endcase
  end

endmodule

// File: rtl/fsh_window.sv
// Picks an N-bit window from the 2N-1 bit word, one 2:1 stage per offset bit.
module fsh_window #(
  parameter int WIDTH = 8,
  localparam int AMT_W = $clog2(WIDTH),
  localparam int ZW = 2 * WIDTH - 1
) (
  input  logic [ZW-1:0]    z_i,
  input  logic [AMT_W-1:0] off_i,
  output logic [WIDTH-1:0] y_o
);

  // Stage j handles offset bit s = AMT_W-1-j; each stage trims 2^s bits.
  for (genvar j = 0; j < AMT_W; j++) begin : g_stg
    localparam int S    = AMT_W - 1 - j;
    localparam int STEP = 1 << S;
    localparam int IW   = WIDTH + 2 * STEP - 1;
    localparam int OW   = WIDTH + STEP - 1;
    logic [IW-1:0] din;
    logic [OW-1:0] dout;
    if (j == 0) begin : g_head
      assign din = z_i;
    end else begin : g_link
      assign din = g_stg[j-1].dout;
    end
    assign dout = off_i[S] ? din[IW-1:STEP] : din[OW-1:0];
  end

  assign y_o = g_stg[AMT_W-1].dout;

endmodule

// File: rtl/funnel_shifter.sv
module funnel_shifter
  import funnel_shifter_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int AMT_W = $clog2(WIDTH),
  localparam int ZW = 2 * WIDTH - 1
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic [2:0]       mode_i,
  output logic [WIDTH-1:0] y_o
);

  logic [ZW-1:0]    zword;
  logic [AMT_W-1:0] offset;

  fsh_fill #(.WIDTH(WIDTH)) fill_i (
    .a_i   (a_i),
    .amt_i (amt_i),
    .mode_i(mode_i),
    .z_o   (zword),
    .off_o (offset)
  );

  fsh_window #(.WIDTH(WIDTH)) win_i (
    .z_i  (zword),
    .off_i(offset),
    .y_o  (y_o)
  );

  // Port-level checks; skipped while any input is unknown (R8: combinational).
  always_comb begin
    if (!$isunknown({a_i, amt_i, mode_i})) begin
      if (mode_i == 3'd0)
        assert_rotr_ones_R1: assert ($countones(y_o) == $countones(a_i));
      if (mode_i == 3'd3)
        assert_rotl_ones_R4: assert ($countones(y_o) == $countones(a_i));
      if (mode_i == 3'd1 && amt_i != '0)
        assert_lsr_msb_zero_R2: assert (y_o[WIDTH-1] == 1'b0);
      if (mode_i == 3'd2)
        assert_asr_sign_kept_R3: assert (y_o[WIDTH-1] == a_i[WIDTH-1]);
      if ((mode_i == 3'd4 || mode_i == 3'd5) && amt_i != '0)
        assert_lsl_lsb_zero_R5: assert (y_o[0] == 1'b0);
      if (mode_i <= 3'd5 && amt_i == '0)
        assert_zero_amt_identity_R6: assert (y_o == a_i);
      if (mode_i >= 3'd6)
        assert_unused_pass_R7: assert (y_o == a_i);
    end
  end

endmodule

// File: tb/funnel_shifter_tb_top.sv
`timescale 1ns/1ps
module funnel_shifter_tb_top;

  localparam int WIDTH = 8;
  localparam int AMT_W = $clog2(WIDTH);

  logic clk;
  logic [WIDTH-1:0] a;
  logic [AMT_W-1:0] amt;
  logic [2:0]       mode;
  logic [WIDTH-1:0] y;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  funnel_shifter #(.WIDTH(WIDTH)) dut_i (
    .a_i   (a),
    .amt_i (amt),
    .mode_i(mode),
    .y_o   (y)
  );

  function automatic logic [WIDTH-1:0] model(input logic [WIDTH-1:0] av,
                                             input int k, input int m);
    logic [WIDTH-1:0] r;
    r = '0;
    for (int j = 0; j < WIDTH; j++) begin
      case (m)
        0: r[j] = av[(j + k) % WIDTH];
        1: r[j] = (j + k < WIDTH) ? av[j + k] : 1'b0;
        2: r[j] = (j + k < WIDTH) ? av[j + k] : av[WIDTH-1];
        3: r[j] = av[(j - k + WIDTH) % WIDTH];
        4, 5: r[j] = (j >= k) ? av[j - k] : 1'b0;
        default: r[j] = av[j];
      endcase
    end
    return r;
  endfunction

  function automatic string tag(input int k, input int m);
    if (m >= 6) return "R7";
    if (k == 0) return "R6";
    case (m)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string req, input logic [WIDTH-1:0] exp);
    checks++;
    if (y !== exp) begin
      errors++;
      $display("FAIL %s: a=%h k=%0d mode=%0d actual=%h expected=%h",
               req, a, amt, mode, y, exp);
    end
  endtask

  initial begin
    a = '0; amt = '0; mode = '0;
    @(negedge clk);
    check("R8", '0);                        // idle inputs give zero output
    // R8: result visible within the same cycle the inputs change
    @(posedge clk); a = 8'hB0; amt = 3'd1; mode = 3'd1;
    @(negedge clk); check("R2", 8'h58);
    @(posedge clk); mode = 3'd2;
    @(negedge clk); check("R3", 8'hD8);
    @(posedge clk); mode = 3'd0; a = 8'h01;
    @(negedge clk); check("R1", 8'h80);
    @(posedge clk); mode = 3'd5; a = 8'hB0;
    @(negedge clk); check("R5", 8'h60);
    // Exhaustive sweep of every mode, operand and amount
    for (int m = 0; m < 8; m++) begin
      for (int av = 0; av < (1 << WIDTH); av++) begin
        for (int k = 0; k < WIDTH; k++) begin
          @(posedge clk);
          mode = m[2:0];
          a    = av[WIDTH-1:0];
          amt  = k[AMT_W-1:0];
          @(negedge clk);
          check(tag(k, m), model(av[WIDTH-1:0], k, m));
        end
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule